// File: doc/BRIEF.md
# Oversample-Locked SAR Convert Trigger and Sample Aligner

This block makes a successive-approximation converter sample in lockstep with a delta-sigma converter, so that the two data streams cannot drift apart over a long run. It does not use a timer of its own. It watches the delta-sigma oversample clock, brings it into the system clock domain, and counts its rising edges. Once every `DIV_N` counted edges it raises a single-cycle convert strobe toward the SAR interface. The SAR rate is therefore always an exact integer fraction of the oversample clock. For example, a 12.8 MHz oversample clock with `DIV_N = 16` gives 800 kHz.

The SAR samples that come back are delayed by a fixed whole number of samples, `DELAY_D`. This lines them up with the delta-sigma output, which lags its input by the filter's group delay. Any fractional part of that group delay is left uncompensated. The delay acts on the full multi-channel sample vector at once. A synchronous clear input restarts the edge count, so the convert phase can be realigned.

Top module: `sar_lockstep_trigger`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `conv_strobe` and `aligned_valid` are 0.
- R2: `conv_strobe` is high for exactly one `clk` cycle on every `DIV_N`-th rising edge of `osc_clk_in`, counted from reset. It rises after the third `clk` rising edge that follows the input's rising transition: two synchronizer flops and one output register.
- R3: A falling edge of `osc_clk_in`, or a level held constant for any number of cycles, produces no strobe and does not advance the count.
- R4: A one-cycle `cnt_clr` restarts the count. No strobe appears in the cycle after the clear. The next strobe comes on the `DIV_N`-th rising edge after the clear.
- R5: After reset, `aligned_valid` stays 0 for the first `DELAY_D` samples accepted with `sar_valid` high.
- R6: When the `(DELAY_D+k+1)`-th sample is accepted, `aligned_valid` is 1 in the following cycle. In that cycle, `aligned_data` equals the complete `k`-th accepted vector (all channels, channel 0 in the low bits).
- R7: In any cycle after one in which `sar_valid` is 0, `aligned_valid` is 0 and `aligned_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk_in | input | 1 | Delta-sigma oversample clock, asynchronous to `clk` |
| cnt_clr | input | 1 | Synchronous clear of the edge counter |
| conv_strobe | output | 1 | One-cycle SAR convert request |
| sar_valid | input | 1 | Qualifies `sar_data` |
| sar_data | input | NUM_CH*SAMPLE_W | SAR result vector, channel 0 in the low bits |
| aligned_valid | output | 1 | Qualifies `aligned_data` |
| aligned_data | output | NUM_CH*SAMPLE_W | SAR vector delayed by `DELAY_D` samples |

## Verification
The bench drives each rise of the oversample clock at a falling `clk` edge. It expects a strobe only at the third falling edge after that rise, and at no other sample point in the pulse window. A strobe that is early, late or wider than one cycle therefore fails the check. For the delay path, each vector is presented at a falling edge and the result is read one falling edge later, which is one register away. On idle cycles in between, the bench checks that the output is not valid and that the data is unchanged. A clear pulse and a reset in the middle of the stream each restart their own count. The bench then checks the exact edge number or sample number at which output resumes.

// File: rtl/sar_lock_pkg.sv
package sar_lock_pkg;

    // Number of flops between the asynchronous oversample clock and the edge detector.
    localparam int unsigned SYNC_DEPTH = 2;

    // Priming state of the delay buffer.
    typedef enum logic {
        BUF_PRIME  = 1'b0,
        BUF_STEADY = 1'b1
    } buf_state_e;

    // Edge detector history: synchronized level and the level one cycle earlier.
    typedef struct packed {
        logic cur_lvl;
        logic old_lvl;
    } edge_hist_t;

    // Modular increment for a circular index.
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync
    import sar_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_async,
    output logic rise_pulse
);
    logic [SYNC_DEPTH-1:0] stage_q;
    edge_hist_t            hist;
    logic                  prev_q;

    generate
        for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= 1'b0;
                    else     stage_q[s] <= lvl_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= 1'b0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[SYNC_DEPTH-1];
    end

    always_comb begin
        hist.cur_lvl = stage_q[SYNC_DEPTH-1];
        hist.old_lvl = prev_q;
        rise_pulse   = hist.cur_lvl & ~hist.old_lvl;
    end

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/conv_divider.sv
module conv_divider
    import sar_lock_pkg::*;
#(
    parameter int unsigned DIV_N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic strobe
);
    localparam int unsigned CNT_W = (DIV_N > 2) ? $clog2(DIV_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);

    logic [CNT_W-1:0] count_q;
    logic             at_last;

    assign at_last = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
            strobe  <= 1'b0;
        end else if (tick) begin
            count_q <= at_last ? '0 : count_q + 1'b1;
            strobe  <= at_last;
        end else begin
            strobe  <= 1'b0;
        end
    end

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
    // R2
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(tick));
    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= LAST);
    // R4
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !strobe);

endmodule

// File: rtl/sample_delay_line.sv
module sample_delay_line
    import sar_lock_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned DELAY_D = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned PTR_W  = (DELAY_D > 1) ? $clog2(DELAY_D) : 1;
    localparam int unsigned FILL_W = $clog2(DELAY_D + 1);

    logic [DATA_W-1:0] ring [DELAY_D];
    logic [PTR_W-1:0]  wptr_q;
    logic [FILL_W-1:0] fill_q;
    buf_state_e        state_q;

    always_ff @(posedge clk) begin
        if (in_valid) ring[wptr_q] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q    <= '0;
            fill_q    <= '0;
            state_q   <= BUF_PRIME;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid) begin
            wptr_q <= PTR_W'(wrap_inc(int'(wptr_q), DELAY_D));
            if (state_q == BUF_STEADY) begin
                out_valid <= 1'b1;
                out_data  <= ring[wptr_q];
            end else begin
                out_valid <= 1'b0;
                fill_q    <= fill_q + 1'b1;
                if (fill_q == FILL_W'(DELAY_D - 1)) state_q <= BUF_STEADY;
            end
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R6
    out_follows_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    // R7
    idle_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R5
    prime_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUF_PRIME) |=> !out_valid);

endmodule

// File: rtl/sar_lockstep_trigger.sv
module sar_lockstep_trigger
    import sar_lock_pkg::*;
#(
    parameter int unsigned DIV_N    = 16,
    parameter int unsigned DELAY_D  = 40,
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         osc_clk_in,
    input  logic                         cnt_clr,
    output logic                         conv_strobe,
    input  logic                         sar_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   sar_data,
    output logic                         aligned_valid,
    output logic [NUM_CH*SAMPLE_W-1:0]   aligned_data
);
    localparam int unsigned VEC_W = NUM_CH * SAMPLE_W;

    logic osc_rise;

    osc_edge_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .lvl_async  (osc_clk_in),
        .rise_pulse (osc_rise)
    );

    conv_divider #(
        .DIV_N (DIV_N)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_clr),
        .tick   (osc_rise),
        .strobe (conv_strobe)
    );

    sample_delay_line #(
        .DATA_W  (VEC_W),
        .DELAY_D (DELAY_D)
    ) u_dly (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sar_valid),
        .in_data   (sar_data),
        .out_valid (aligned_valid),
        .out_data  (aligned_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!conv_strobe && !aligned_valid));

endmodule

// File: tb/test_sar_lockstep_trigger.sv
module test_sar_lockstep_trigger;
    localparam int unsigned N  = 4;
    localparam int unsigned D  = 5;
    localparam int unsigned CH = 2;
    localparam int unsigned W  = 12;
    localparam int unsigned DW = CH * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          osc = 1'b0;
    logic          clr = 1'b0;
    logic          strobe;
    logic          s_valid = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          a_valid;
    logic [DW-1:0] a_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] last_out = '0;

    always #2.5 clk = ~clk;

    sar_lockstep_trigger #(
        .DIV_N(N), .DELAY_D(D), .NUM_CH(CH), .SAMPLE_W(W)
    ) i_sar_lockstep_trigger (
        .clk(clk), .rst(rst), .osc_clk_in(osc), .cnt_clr(clr),
        .conv_strobe(strobe), .sar_valid(s_valid), .sar_data(s_data),
        .aligned_valid(a_valid), .aligned_data(a_data)
    );

    function automatic logic [DW-1:0] vec(input int k);
        return {W'(k * 37 + 5), W'(k * 91 + 3)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: outputs quiet during reset
        check(strobe == 1'b0 && a_valid == 1'b0, "R1", "quiet in reset",
              {strobe, a_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(strobe == 1'b0 && a_valid == 1'b0, "R1", "quiet after reset",
              {strobe, a_valid}, 0);
        last_out = '0;
    endtask

    // One rising and falling oscillator edge; the strobe is expected only at sample 2.
    task automatic osc_pulse(input bit hit, input string req);
        int hits = 0;
        int pos  = -1;
        osc = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (strobe) begin hits++; pos = i; end
            if (i == 2) osc = 1'b0;
        end
        check(hit ? (hits == 1 && pos == 2) : (hits == 0), req, "strobe hits/pos",
              hits * 16 + pos + 1, hit ? 16 + 3 : 0);
    endtask

    task automatic t_divide();
        // R2: strobe on every N-th rising edge, one cycle wide
        for (int e = 1; e <= 3 * N; e++) osc_pulse((e % N) == 0, "R2");
    endtask

    task automatic t_level_hold();
        int hits = 0;
        // R3: held levels and falling edges make no strobe
        osc = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (strobe) hits++;
        end
        osc = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (strobe) hits++;
        end
        check(hits == 0, "R3", "strobes on static level", hits, 0);
        // one rising edge was consumed: count now 1; finish the period
        for (int e = 2; e <= N; e++) osc_pulse(e == N, "R3");
    endtask

    task automatic t_clear();
        osc_pulse(1'b0, "R4");
        osc_pulse(1'b0, "R4");
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(strobe == 1'b0, "R4", "strobe after clear", strobe, 0);
        // R4: strobe only on the N-th edge after the clear
        for (int e = 1; e <= N; e++) osc_pulse(e == N, "R4");
    endtask

    task automatic push(input logic [DW-1:0] d, input bit exp_v,
                        input logic [DW-1:0] exp_d, input string req);
        s_valid = 1'b1;
        s_data  = d;
        @(negedge clk);
        s_valid = 1'b0;
        check(a_valid == exp_v, req, "aligned_valid", a_valid, exp_v);
        if (exp_v) begin
            check(a_data == exp_d, req, "aligned_data", a_data, exp_d);
            last_out = exp_d;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            // R7: no valid output and held data on idle cycles
            check(a_valid == 1'b0 && a_data == last_out, "R7", "idle output",
                  {a_valid, a_data}, {1'b0, last_out});
        end
    endtask

    task automatic t_delay();
        do_reset();
        // R5: first D samples produce nothing
        for (int k = 0; k < D; k++) begin
            push(vec(k), 1'b0, '0, "R5");
            if (k % 2 == 1) idle(1);
        end
        // R6: later samples emit the vector D samples older
        for (int k = D; k < D + 3; k++) push(vec(k), 1'b1, vec(k - D), "R6");
        idle(3);
        for (int k = D + 3; k < D + 8; k++) begin
            push(vec(k), 1'b1, vec(k - D), "R6");
            if (k == D + 5) idle(2);
        end
    endtask

    task automatic t_reprime();
        do_reset();
        // R5: reset mid-stream restarts the priming count
        for (int k = 0; k < D; k++) push(vec(100 + k), 1'b0, '0, "R5");
        push(vec(100 + D), 1'b1, vec(100), "R6");
        idle(1);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_divide();
        t_level_hold();
        t_clear();
        t_delay();
        t_reprime();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule